// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Layered Write Lock

This block is the slave side of a 256-byte serial memory reached over a two-wire clock/data bus. It runs in the chip's system clock domain and takes the bus clock and data lines as plain inputs, which it oversamples through a short synchronizer. It drives the data line only by pulling it low, through an enable output that an open-drain pad turns into a low level. Three strap inputs set the low bits of the slave's select code, so eight of these slaves can share one bus.

A host addresses a byte with one word-address byte and can write one byte or a run of up to a page (16 bytes). It can read at the current address, read at any address after a dummy write of the address (random read), or keep reading byte after byte. Written bytes go into a page staging buffer. They reach the storage array during a self-timed commit window that opens at the STOP ending the write. While that window is open the slave refuses its select code, so the host can poll for completion.

Writes are gated at three levels. A write-protect input blocks the whole array. A lock flag, once set by a dedicated command, makes the lower half read-only. With neither active, every byte is writable. The lock flag cannot be cleared by any bus traffic, only by the block's reset.

Top module: `tw_prom_slave`

## Requirements
- R1: After reset the data-line enable is low, the slave is idle, and the lock flag is clear (a read select of code 0110 is acknowledged).
- R2: A select byte is acknowledged only when its upper nibble is 1010 (memory) or 0110 (lock) and bits 3..1 equal `strap_i`; bit 0 is the direction (1 = read). Any other select byte leaves SDA released on the ninth clock.
- R3: Every accepted address or data byte written by the host is acknowledged by pulling SDA low for the whole ninth SCL clock.
- R4: A write of select, word address and data bytes followed by STOP stores the data, and a later random read (write select, address, repeated START, read select) returns it. Data bytes followed by a repeated START instead of a STOP are dropped.
- R5: During a write only address bits 3..0 advance after each data byte, so a run wraps inside its 16-byte page. Runs shorter than 16 bytes are legal, and a run longer than 16 overwrites its earliest bytes.
- R6: During a read the full 8-bit address advances after each byte sent, rolling from FFh to 00h. The read ends when the host answers a byte with no acknowledge.
- R7: The commit of a write starts at its STOP. For `WRITE_CLKS` clocks after that every select byte is refused, and afterwards it is acknowledged again.
- R8: While `wp_i` is high, data bytes are acknowledged but no location changes.
- R9: The sequence select 0110 with direction 0, one dummy address byte, one dummy data byte and STOP sets the lock flag. A read select of code 0110 is then refused, where before it was acknowledged.
- R10: With the lock flag set and `wp_i` low, bytes aimed at 00h..7Fh are acknowledged but not stored, while 80h..FFh still accept writes.
- R11: Once set, the lock flag stays set through any bus traffic and any `wp_i` level; only `rst_n` clears it.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, clears state and the lock flag |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Strap value matched against select bits 3..1 |
| wp_i | input | 1 | High blocks writes to the whole array |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The host model sends byte writes, full, partial and over-long page runs, random reads and long sequential reads. These separate page-local address wrap from full 8-bit roll-over and show whether staged bytes land at the right offsets. Select bytes with a wrong strap or wrong code, polls sent right after a STOP, and polls after the window show the acknowledge rule on its own. Writes repeated under each protection level show which half of the array each level freezes. A reset after the lock shows that the flag is sticky except against reset. A seeded random phase adds writes of random length, start and data, each followed by a read-back compared with a bench model of the array.

// File: rtl/tw_prom_pkg.sv
package tw_prom_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [3:0] MEM_CODE  = 4'b1010;
    localparam logic [3:0] LOCK_CODE = 4'b0110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_BYTE_END,
        PH_ACK,
        PH_TX,
        PH_HOST_ACK,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        K_SELECT,
        K_WORD,
        K_DATA
    } kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

endpackage

// File: rtl/tw_line_sense.sv
module tw_line_sense
    import tw_prom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] scl_sr_d, scl_sr_q;
    logic [SR_W-1:0] sda_sr_d, sda_sr_q;
    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_sr_d = {scl_sr_q[SR_W-2:0], scl_i};
        sda_sr_d = {sda_sr_q[SR_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
        end else begin
            scl_sr_q <= scl_sr_d;
            sda_sr_q <= sda_sr_d;
        end
    end

    assign scl_now = scl_sr_q[SR_W-2];
    assign scl_old = scl_sr_q[SR_W-1];
    assign sda_now = sda_sr_q[SR_W-2];
    assign sda_old = sda_sr_q[SR_W-1];

    always_comb begin
        ev_o.rise  = scl_now & ~scl_old;
        ev_o.fall  = ~scl_now & scl_old;
        ev_o.start = scl_now & scl_old & sda_old & ~sda_now;
        ev_o.stop  = scl_now & scl_old & ~sda_old & sda_now;
        ev_o.sda   = sda_now;
    end

endmodule

// File: rtl/tw_prom_store.sv
module tw_prom_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/tw_prom_slave.sv
module tw_prom_slave
    import tw_prom_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int WRITE_CLKS  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BUSY_W = $clog2(WRITE_CLKS + 1);
    localparam int WALK_W = PAGE_W + 1;

    typedef struct packed {
        phase_e                             ph;
        kind_e                              kind;
        logic                               rd;
        logic                               lock_cmd;
        logic                               lock_arm;
        logic                               do_ack;
        logic                               host_ack;
        logic [2:0]                         nbit;
        logic [BYTE_W-1:0]                  sh;
        logic [ADDR_W-1:0]                  addr;
        logic                               pend;
        logic [PAGE_BYTES-1:0]              mask;
        logic [PAGE_BYTES-1:0][BYTE_W-1:0]  stage;
        logic                               locked;
        logic [BUSY_W-1:0]                  busy;
        logic [WALK_W-1:0]                  walk;
    } ctl_t;

    ctl_t q_r, n_r;
    line_ev_t ev;

    logic              store_we;
    logic [ADDR_W-1:0] store_waddr;
    logic [BYTE_W-1:0] store_wdata;
    logic [BYTE_W-1:0] store_rdata;

    logic [BYTE_W-1:0] full_byte;
    logic [PAGE_W-1:0] low_idx;
    logic [PAGE_W-1:0] low_next;
    logic [PAGE_W-1:0] walk_idx;
    logic              can_write;

    tw_line_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    tw_prom_store #(.AW(ADDR_W), .DW(BYTE_W)) store_i (
        .clk   (clk),
        .we    (store_we),
        .waddr (store_waddr),
        .wdata (store_wdata),
        .raddr (q_r.addr),
        .rdata (store_rdata)
    );

    always_comb begin
        n_r         = q_r;
        store_we    = 1'b0;
        store_waddr = '0;
        store_wdata = '0;
        full_byte   = {q_r.sh[BYTE_W-2:0], ev.sda};
        low_idx     = q_r.addr[PAGE_W-1:0];
        low_next    = low_idx + PAGE_W'(1);
        walk_idx    = q_r.walk[PAGE_W-1:0];
        can_write   = !wp_i && !(q_r.locked && !q_r.addr[ADDR_W-1]);

        // commit window: walk the staged page once, then wait out the timer
        if (q_r.busy != '0) begin
            n_r.busy = q_r.busy - BUSY_W'(1);
            if (q_r.walk < WALK_W'(PAGE_BYTES)) begin
                n_r.walk = q_r.walk + WALK_W'(1);
                if (q_r.mask[walk_idx]) begin
                    store_we           = 1'b1;
                    store_waddr        = {q_r.addr[ADDR_W-1:PAGE_W], walk_idx};
                    store_wdata        = q_r.stage[walk_idx];
                    n_r.mask[walk_idx] = 1'b0;
                end
            end
        end

        if (ev.start) begin
            n_r.ph       = PH_RX;
            n_r.kind     = K_SELECT;
            n_r.nbit     = '0;
            n_r.rd       = 1'b0;
            n_r.lock_cmd = 1'b0;
            n_r.lock_arm = 1'b0;
            n_r.pend     = 1'b0;
            if (q_r.busy == '0) begin
                n_r.mask = '0;
            end
        end else if (ev.stop) begin
            n_r.ph = PH_IDLE;
            if (q_r.pend) begin
                n_r.busy = BUSY_W'(WRITE_CLKS);
                n_r.walk = '0;
                n_r.pend = 1'b0;
            end
            if (q_r.lock_arm) begin
                n_r.locked   = 1'b1;
                n_r.lock_arm = 1'b0;
                n_r.busy     = BUSY_W'(WRITE_CLKS);
                n_r.walk     = WALK_W'(PAGE_BYTES);
            end
        end else begin
            case (q_r.ph)
                PH_RX: begin
                    if (ev.rise) begin
                        n_r.sh   = full_byte;
                        n_r.nbit = q_r.nbit + 3'd1;
                        if (q_r.nbit == 3'd7) begin
                            n_r.ph     = PH_BYTE_END;
                            n_r.do_ack = 1'b0;
                            case (q_r.kind)
                                K_SELECT: begin
                                    if (q_r.busy == '0 && full_byte[3:1] == strap_i) begin
                                        if (full_byte[7:4] == MEM_CODE) begin
                                            n_r.do_ack = 1'b1;
                                            n_r.rd     = full_byte[0];
                                            n_r.kind   = K_WORD;
                                        end else if (full_byte[7:4] == LOCK_CODE) begin
                                            n_r.do_ack   = !full_byte[0] || !q_r.locked;
                                            n_r.rd       = full_byte[0];
                                            n_r.lock_cmd = 1'b1;
                                            n_r.kind     = K_WORD;
                                        end
                                    end
                                end
                                K_WORD: begin
                                    n_r.do_ack = 1'b1;
                                    n_r.kind   = K_DATA;
                                    if (!q_r.lock_cmd) begin
                                        n_r.addr = full_byte;
                                    end
                                end
                                K_DATA: begin
                                    n_r.do_ack = 1'b1;
                                    if (q_r.lock_cmd) begin
                                        n_r.lock_arm = 1'b1;
                                    end else begin
                                        n_r.pend = 1'b1;
                                        if (can_write) begin
                                            n_r.stage[low_idx] = full_byte;
                                            n_r.mask[low_idx]  = 1'b1;
                                        end
                                        n_r.addr = {q_r.addr[ADDR_W-1:PAGE_W], low_next};
                                    end
                                end
                                default: n_r.do_ack = 1'b0;
                            endcase
                        end
                    end
                end
                PH_BYTE_END: begin
                    if (ev.fall) begin
                        n_r.ph = q_r.do_ack ? PH_ACK : PH_HOLD;
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        if (q_r.rd && q_r.lock_cmd) begin
                            n_r.ph = PH_HOLD;
                        end else if (q_r.rd) begin
                            n_r.ph   = PH_TX;
                            n_r.sh   = store_rdata;
                            n_r.addr = q_r.addr + ADDR_W'(1);
                            n_r.nbit = '0;
                        end else begin
                            n_r.ph   = PH_RX;
                            n_r.nbit = '0;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (q_r.nbit == 3'd7) begin
                            n_r.ph       = PH_HOST_ACK;
                            n_r.host_ack = 1'b0;
                        end else begin
                            n_r.sh   = {q_r.sh[BYTE_W-2:0], 1'b0};
                            n_r.nbit = q_r.nbit + 3'd1;
                        end
                    end
                end
                PH_HOST_ACK: begin
                    if (ev.rise) begin
                        n_r.host_ack = !ev.sda;
                    end else if (ev.fall) begin
                        if (q_r.host_ack) begin
                            n_r.ph   = PH_TX;
                            n_r.sh   = store_rdata;
                            n_r.addr = q_r.addr + ADDR_W'(1);
                            n_r.nbit = '0;
                        end else begin
                            n_r.ph = PH_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= n_r;
        end
    end

    assign sda_oe_o = (q_r.ph == PH_ACK) || (q_r.ph == PH_TX && !q_r.sh[BYTE_W-1]);

endmodule

// File: rtl/tw_prom_slave_chk.sv
module tw_prom_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       busy,
    input logic       locked,
    input logic       we,
    input logic [7:0] waddr
);
    // R12: drive changes only with SCL low
    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R7: no acknowledge while the commit window is open
    p_quiet_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe_o);

    // R7: array updates only inside the commit window
    p_write_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> busy);

    // R11: lock never drops without reset
    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R10: lower half untouched once locked
    p_lower_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !waddr[7]) |-> !locked);
endmodule

bind tw_prom_slave tw_prom_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .busy     (q_r.busy != '0),
    .locked   (q_r.locked),
    .we       (store_we),
    .waddr    (store_waddr)
);

// File: tb/tw_prom_slave_tb_top.sv
module tw_prom_slave_tb_top;
    localparam int Q = 6;
    localparam int WCLKS = 600;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_MEM_W  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_MEM_R  = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] SEL_LOCK_W = {4'b0110, STRAP, 1'b0};
    localparam logic [7:0] SEL_LOCK_R = {4'b0110, STRAP, 1'b1};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_h & ~sda_oe;

    tw_prom_slave #(.WRITE_CLKS(WCLKS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [256];
    bit         known [256];
    bit         lock_m = 1'b0;
    logic [7:0] wbuf [32];

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit writable_m(input logic [7:0] a);
        return !wp && !(lock_m && !a[7]);
    endfunction

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic wbit(input logic b);
        sda_h = b;    tick(Q);
        scl_h = 1'b1; tick(2 * Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(x);
        ack = !x;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(!give_ack);
    endtask

    task automatic wait_ready();
        bit ack = 1'b0;
        for (int k = 0; k < 20 && !ack; k++) begin
            bus_start(); wbyte(SEL_MEM_W, ack); bus_stop();
        end
        check("R7 ready after commit", ack, 1);
    endtask

    task automatic mem_write(input logic [7:0] a, input int n, input bit do_wait, input string tag);
        bit ack;
        logic [7:0] ad;
        bus_start();
        wbyte(SEL_MEM_W, ack); check("R2 select ack", ack, 1);
        wbyte(a, ack);         check("R3 word ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack);
            check({tag, " R3 data ack"}, ack, 1);
            ad = {a[7:4], a[3:0] + 4'(i)};
            if (writable_m(ad)) begin
                model[ad] = wbuf[i];
                known[ad] = 1'b1;
            end
        end
        bus_stop();
        if (do_wait) wait_ready();
    endtask

    task automatic mem_read(input logic [7:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] v;
        logic [7:0] ad;
        bus_start();
        wbyte(SEL_MEM_W, ack); check({tag, " select"}, ack, 1);
        wbyte(a, ack);         check({tag, " word"}, ack, 1);
        bus_start();
        wbyte(SEL_MEM_R, ack); check({tag, " read select"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i < n - 1, v);
            ad = a + 8'(i);
            if (known[ad]) check({tag, " read data"}, int'(v), int'(model[ad]));
        end
        bus_stop();
    endtask

    task automatic lock_query(output bit ack);
        bus_start(); wbyte(SEL_LOCK_R, ack); bus_stop();
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] ra;
        int len;
        void'($urandom(32'h1c0ffee5));
        for (int i = 0; i < 256; i++) known[i] = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R1 drive released after reset", sda_oe, 0);
        lock_query(ack);
        check("R1 lock clear after reset", ack, 1);

        // R2 select filtering
        bus_start(); wbyte({4'b1010, 3'b010, 1'b0}, ack); bus_stop();
        check("R2 wrong strap refused", ack, 0);
        bus_start(); wbyte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
        check("R2 wrong code refused", ack, 0);

        // R4 single byte
        wbuf[0] = 8'hA7;
        mem_write(8'h35, 1, 1'b1, "R4");
        mem_read(8'h35, 1, "R4");

        // R4 repeated START drops staged bytes
        wbuf[0] = 8'h5A;
        bus_start(); wbyte(SEL_MEM_W, ack); wbyte(8'h35, ack); wbyte(wbuf[0], ack);
        bus_start(); wbyte(SEL_MEM_W, ack); wbyte(8'h35, ack);
        bus_start(); wbyte(SEL_MEM_R, ack);
        begin
            logic [7:0] v;
            rbyte(1'b0, v);
            check("R4 dropped without STOP", int'(v), 8'hA7);
        end
        bus_stop();

        // R7 commit window
        wbuf[0] = 8'h3C;
        mem_write(8'h40, 1, 1'b0, "R7");
        bus_start(); wbyte(SEL_MEM_W, ack); bus_stop();
        check("R7 select refused during commit", ack, 0);
        wait_ready();
        mem_read(8'h40, 1, "R7");

        // R5 page writes
        fill(16); mem_write(8'h10, 16, 1'b1, "R5 full page");
        fill(6);  mem_write(8'h1C, 6, 1'b1, "R5 partial wrap");
        mem_read(8'h10, 16, "R5");
        fill(18); mem_write(8'h20, 18, 1'b1, "R5 overlong");
        mem_read(8'h20, 16, "R5");

        // R6 sequential roll-over
        fill(16); mem_write(8'hF0, 16, 1'b1, "R6 fill");
        fill(16); mem_write(8'h00, 16, 1'b1, "R6 fill");
        mem_read(8'hFC, 8, "R6 roll");

        // R8 hardware protect
        fill(3); mem_write(8'h90, 3, 1'b1, "R8 prefill");
        wp = 1'b1;
        fill(3); mem_write(8'h90, 3, 1'b1, "R8 blocked");
        wp = 1'b0;
        mem_read(8'h90, 3, "R8");

        // random phase, all writable
        for (int it = 0; it < 4; it++) begin
            ra  = 8'($urandom);
            len = 1 + int'($urandom % 10);
            fill(len);
            mem_write(ra, len, 1'b1, "R5 random");
            mem_read({ra[7:4], 4'h0}, 16, "R5 random");
        end

        // R9 lock command
        bus_start();
        wbyte(SEL_LOCK_W, ack); check("R9 lock select", ack, 1);
        wbyte(8'h00, ack);      check("R9 dummy word", ack, 1);
        wbyte(8'h00, ack);      check("R9 dummy data", ack, 1);
        bus_stop();
        lock_m = 1'b1;
        wait_ready();
        lock_query(ack);
        check("R9 lock reported", ack, 0);

        // R10 lower half frozen, upper writable
        fill(4); mem_write(8'h08, 4, 1'b1, "R10 lower");
        mem_read(8'h08, 4, "R10 lower");
        fill(4); mem_write(8'h88, 4, 1'b1, "R10 upper");
        mem_read(8'h88, 4, "R10 upper");

        // R11 sticky until reset
        wp = 1'b1; tick(20); wp = 1'b0;
        lock_query(ack);
        check("R11 lock kept", ack, 0);
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        lock_m = 1'b0;
        check("R1 drive released after second reset", sda_oe, 0);
        lock_query(ack);
        check("R11 reset clears lock", ack, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule